// File: doc/BRIEF.md
# Sleep Clock-Request and NMI Mask Controller

This block sits next to a processor core on an APB slave port. It keeps a per-line mask over the core's interrupt inputs. When any unmasked line is active, it raises one non-maskable interrupt request. The masks live in two registers. The first covers lines 0 to 31 and the second covers lines 32 to 51. Both are cleared by the core's warm reset as well as by the system reset.

A third register controls sleep behaviour. A light-sleep option decides whether an ordinary sleep keeps the system-level clock request up. A deep sleep always drops the clock request. A separate bit asks the interrupt controller to make the next deep sleep a wake-up-interrupt-controller sleep. The controller's acknowledge reads back as a status bit in the same register.

When the clock request comes back after a sleep that dropped it, a wake-ready output stays low for a fixed delay while the clocks restart. The default delay is 5 cycles. If the clock request never fell, wake-ready stays high.

Top module: `nmi_sleep_ctl`

## Requirements
- R1: The register at byte offset 0x00 holds a 32-bit read/write mask for interrupt lines 0 to 31. Bit n of the register belongs to line n. It resets to 0.
- R2: The register at byte offset 0x04 holds the mask for lines 32 to 51 in bits 19:0. Bit n of the register belongs to line 32+n. It resets to 0. Bits 31:20 ignore writes and read as 0.
- R3: A low level on `rst_warm_n` clears both mask registers. It leaves the sleep-control register unchanged.
- R4: The sleep-control register is at byte offset 0x08 and resets to 0x2. Bit 0 is light-sleep. Bit 1 is the WIC-enable request and drives `wic_en_req`. Bit 2 reads the current level of `wic_en_ack`, and writes to it have no effect. Bits 31:3 read as 0.
- R5: `nmi_req` is high exactly when some line has both its `irq_in` bit and its mask bit set. This is a combinational path.
- R6: With light-sleep at 0, `clk_req` is low whenever `sleeping` is high.
- R7: With light-sleep at 1, `clk_req` stays high during a sleep with `sleep_deep` low.
- R8: While `sleeping` and `sleep_deep` are both high, `clk_req` is low, whatever the light-sleep setting.
- R9: `wake_ready` is low while `clk_req` is low. After `clk_req` returns high, `wake_ready` rises on the 5th rising clock edge. If `clk_req` stayed high through a sleep, `wake_ready` stays high.
- R10: `pready` is always 1. During the access phase, `pslverr` is 1 for an unaligned address or an address at 0x0C or above. A write that raises the error changes no register. A read that raises the error returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_sys_n | input | 1 | System reset, active low, asynchronous |
| rst_warm_n | input | 1 | Core warm reset, active low, clears the masks |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error response |
| irq_in | input | NUM_IRQ | Interrupt lines from the system |
| nmi_req | output | 1 | Combined non-maskable interrupt request |
| sleeping | input | 1 | Core reports that it is asleep |
| sleep_deep | input | 1 | Core reports that the sleep is a deep sleep |
| clk_req | output | 1 | System-level clock request |
| wake_ready | output | 1 | Clocks are settled and the core may resume |
| wic_en_req | output | 1 | WIC-enable request to the interrupt controller |
| wic_en_ack | input | 1 | WIC-enable acknowledge from the interrupt controller |

## Verification
A software write to the light-sleep bit can land in the same cycle that the core is already in an ordinary sleep. That changes the clock request in the middle of the sleep and starts the wake-up delay. The bench provokes this case. It holds an ordinary sleep with light-sleep set and clears the bit over APB. It then checks that `clk_req` falls on the write edge and not before. When the sleep ends, it checks that `wake_ready` rises on the 5th following edge. The bench also checks that a mask write lands while interrupt lines are held active, and that `nmi_req` follows on the write edge.

// File: rtl/nsc_pkg.sv
package nsc_pkg;
   localparam int unsigned BANK_W      = 32;
   localparam int unsigned BIT_LIGHT   = 0;
   localparam int unsigned BIT_WIC_REQ = 1;
   localparam int unsigned BIT_WIC_ACK = 2;
endpackage

// File: rtl/nsc_regs.sv
module nsc_regs
   import nsc_pkg::*;
#(
   parameter int unsigned NUM_IRQ = 52,
   parameter int unsigned ADDR_W  = 12
) (
   input  logic                clk,
   input  logic                rst_sys_n,
   input  logic                rst_warm_n,
   input  logic                psel,
   input  logic                penable,
   input  logic                pwrite,
   input  logic [ADDR_W-1:0]   paddr,
   input  logic [BANK_W-1:0]   pwdata,
   output logic [BANK_W-1:0]   prdata,
   output logic                pslverr,
   input  logic                wic_en_ack,
   output logic [NUM_IRQ-1:0]  mask_o,
   output logic                light_o,
   output logic                wic_req_o
);
   localparam int unsigned NUM_BANKS = (NUM_IRQ + BANK_W - 1) / BANK_W;
   localparam int unsigned WORD_W    = ADDR_W - 2;
   localparam int unsigned PAD_W     = NUM_BANKS * BANK_W;
   localparam logic [WORD_W-1:0] SLEEP_IDX = WORD_W'(NUM_BANKS);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("nsc_regs: ADDR_W must be at least 4");
   end
   if (NUM_IRQ < 1 || NUM_BANKS >= (1 << WORD_W)) begin : g_bad_irq
      $error("nsc_regs: NUM_IRQ does not fit the address window");
   end

   logic              access;
   logic              hit;
   logic              wr_en;
   logic [WORD_W-1:0] word;
   logic              mask_rst_n;
   logic [PAD_W-1:0]  mask_pad;

   assign word       = paddr[ADDR_W-1:2];
   assign access     = psel & penable;
   assign hit        = (paddr[1:0] == 2'b00) && (word <= SLEEP_IDX);
   assign pslverr    = access & ~hit;
   assign wr_en      = access & pwrite & hit;
   assign mask_rst_n = rst_sys_n & rst_warm_n;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned LO = b * BANK_W;
      localparam int unsigned W  = ((NUM_IRQ - LO) > BANK_W) ? BANK_W : (NUM_IRQ - LO);
      logic [W-1:0] bank_q;
      always_ff @(posedge clk or negedge mask_rst_n) begin
         if (!mask_rst_n) begin
            bank_q <= '0;
         end else if (wr_en && word == WORD_W'(b)) begin
            bank_q <= pwdata[W-1:0];
         end
      end
      assign mask_o[LO +: W] = bank_q;
   end

   always_ff @(posedge clk or negedge rst_sys_n) begin
      if (!rst_sys_n) begin
         light_o   <= 1'b0;
         wic_req_o <= 1'b1;
      end else if (wr_en && word == SLEEP_IDX) begin
         light_o   <= pwdata[BIT_LIGHT];
         wic_req_o <= pwdata[BIT_WIC_REQ];
      end
   end

   always_comb begin
      mask_pad = '0;
      mask_pad[NUM_IRQ-1:0] = mask_o;
      prdata = '0;
      if (psel && !pwrite && hit) begin
         if (word == SLEEP_IDX) begin
            prdata[BIT_LIGHT]   = light_o;
            prdata[BIT_WIC_REQ] = wic_req_o;
            prdata[BIT_WIC_ACK] = wic_en_ack;
         end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
               if (word == WORD_W'(b)) prdata = mask_pad[b*BANK_W +: BANK_W];
            end
         end
      end
   end
endmodule

// File: rtl/nsc_nmi.sv
module nsc_nmi #(
   parameter int unsigned NUM_IRQ = 52
) (
   input  logic [NUM_IRQ-1:0] irq_in,
   input  logic [NUM_IRQ-1:0] mask,
   output logic               nmi_req
);
   if (NUM_IRQ < 1) begin : g_bad
      $error("nsc_nmi: NUM_IRQ must be positive");
   end
   assign nmi_req = |(irq_in & mask);
endmodule

// File: rtl/nsc_wake.sv
module nsc_wake #(
   parameter int unsigned WAKE_DELAY = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleeping,
   input  logic sleep_deep,
   input  logic light,
   output logic clk_req,
   output logic wake_ready
);
   assign clk_req = ~(sleeping & (sleep_deep | ~light));

   if (WAKE_DELAY == 0) begin : g_nodelay
      assign wake_ready = clk_req;
   end else begin : g_delay
      localparam int unsigned CNT_W = $clog2(WAKE_DELAY + 1);
      localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAKE_DELAY);
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (!clk_req) begin
            cnt_q <= LOAD;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
      assign wake_ready = clk_req && (cnt_q == '0);
   end
endmodule

// File: rtl/nmi_sleep_ctl.sv
module nmi_sleep_ctl #(
   parameter int unsigned NUM_IRQ    = 52,
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned WAKE_DELAY = 5
) (
   input  logic               clk,
   input  logic               rst_sys_n,
   input  logic               rst_warm_n,
   input  logic               psel,
   input  logic               penable,
   input  logic               pwrite,
   input  logic [ADDR_W-1:0]  paddr,
   input  logic [31:0]        pwdata,
   output logic [31:0]        prdata,
   output logic               pready,
   output logic               pslverr,
   input  logic [NUM_IRQ-1:0] irq_in,
   output logic               nmi_req,
   input  logic               sleeping,
   input  logic               sleep_deep,
   output logic               clk_req,
   output logic               wake_ready,
   output logic               wic_en_req,
   input  logic               wic_en_ack
);
   logic [NUM_IRQ-1:0] mask;
   logic               light;

   assign pready = 1'b1;

   nsc_regs #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) i_regs (
      .clk(clk), .rst_sys_n(rst_sys_n), .rst_warm_n(rst_warm_n),
      .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
      .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
      .wic_en_ack(wic_en_ack), .mask_o(mask), .light_o(light),
      .wic_req_o(wic_en_req)
   );

   nsc_nmi #(.NUM_IRQ(NUM_IRQ)) i_nmi (
      .irq_in(irq_in), .mask(mask), .nmi_req(nmi_req)
   );

   nsc_wake #(.WAKE_DELAY(WAKE_DELAY)) i_wake (
      .clk(clk), .rst_n(rst_sys_n), .sleeping(sleeping),
      .sleep_deep(sleep_deep), .light(light), .clk_req(clk_req),
      .wake_ready(wake_ready)
   );
endmodule

// File: rtl/nmi_sleep_ctl_chk.sv
module nmi_sleep_ctl_chk #(
   parameter int unsigned NUM_IRQ    = 52,
   parameter int unsigned WAKE_DELAY = 5
) (
   input logic               clk,
   input logic               rst_sys_n,
   input logic               rst_warm_n,
   input logic               psel,
   input logic               penable,
   input logic               pwrite,
   input logic               pslverr,
   input logic [NUM_IRQ-1:0] irq_in,
   input logic               nmi_req,
   input logic               sleeping,
   input logic               sleep_deep,
   input logic               light,
   input logic               clk_req,
   input logic               wake_ready,
   input logic               wic_en_req
);
   AST_DEEP_DROPS_CLK: assert property (@(posedge clk) disable iff (!rst_sys_n || !rst_warm_n)
      (sleeping && sleep_deep) |-> !clk_req);  // R8
   AST_PLAIN_SLEEP_DROPS: assert property (@(posedge clk) disable iff (!rst_sys_n || !rst_warm_n)
      (sleeping && !light) |-> !clk_req);  // R6
   AST_LIGHT_KEEPS_CLK: assert property (@(posedge clk) disable iff (!rst_sys_n || !rst_warm_n)
      (sleeping && !sleep_deep && light) |-> clk_req);  // R7
   AST_READY_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rst_sys_n || !rst_warm_n)
      wake_ready |-> clk_req);  // R9
   AST_WAKE_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_sys_n || !rst_warm_n)
      ((WAKE_DELAY > 0) && $rose(clk_req)) |-> !wake_ready);  // R9
   AST_ERR_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_sys_n || !rst_warm_n)
      pslverr |-> (psel && penable));  // R10
   AST_NMI_QUIET: assert property (@(posedge clk) disable iff (!rst_sys_n || !rst_warm_n)
      (irq_in == '0) |-> !nmi_req);  // R5
   AST_WIC_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_sys_n || !rst_warm_n)
      !(psel && penable && pwrite) |=> $stable(wic_en_req));  // R4
endmodule

bind nmi_sleep_ctl nmi_sleep_ctl_chk #(.NUM_IRQ(NUM_IRQ), .WAKE_DELAY(WAKE_DELAY)) i_chk (
   .clk(clk), .rst_sys_n(rst_sys_n), .rst_warm_n(rst_warm_n),
   .psel(psel), .penable(penable), .pwrite(pwrite), .pslverr(pslverr),
   .irq_in(irq_in), .nmi_req(nmi_req), .sleeping(sleeping),
   .sleep_deep(sleep_deep), .light(light), .clk_req(clk_req),
   .wake_ready(wake_ready), .wic_en_req(wic_en_req)
);

// File: tb/test_nmi_sleep_ctl.sv
`timescale 1ns/1ps
module test_nmi_sleep_ctl;
   localparam int NI = 52;
   localparam int AW = 12;

   typedef struct packed {
      logic [NI-1:0] mask;
      logic [NI-1:0] irq;
      logic          nmi;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{mask: 52'h0,             irq: 52'hFFFFFFFFFFFFF, nmi: 1'b0},
      '{mask: 52'h0000000000001, irq: 52'h0000000000001, nmi: 1'b1},
      '{mask: 52'h0000080000000, irq: 52'h0000040000000, nmi: 1'b0},
      '{mask: 52'h0000100000000, irq: 52'h0000100000000, nmi: 1'b1},
      '{mask: 52'h8000000000000, irq: 52'h8000000000000, nmi: 1'b1},
      '{mask: 52'hFFFFFFFFFFFFF, irq: 52'h0,             nmi: 1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_sys_n = 1'b0, rst_warm_n = 1'b1;
   logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [31:0]   pwdata = '0;
   logic [31:0]   prdata;
   logic          pready, pslverr;
   logic [NI-1:0] irq_in = '0;
   logic          nmi_req;
   logic          sleeping = 1'b0, sleep_deep = 1'b0;
   logic          clk_req, wake_ready, wic_en_req;
   logic          wic_en_ack = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic        err;
   logic [31:0] rd;

   always #4 clk = ~clk;

   nmi_sleep_ctl i_nmi_sleep_ctl (
      .clk(clk), .rst_sys_n(rst_sys_n), .rst_warm_n(rst_warm_n),
      .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
      .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .irq_in(irq_in), .nmi_req(nmi_req), .sleeping(sleeping),
      .sleep_deep(sleep_deep), .clk_req(clk_req), .wake_ready(wake_ready),
      .wic_en_req(wic_en_req), .wic_en_ack(wic_en_ack)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d, output logic e);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      #1 e = pslverr;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [AW-1:0] a, output logic [31:0] d, output logic e);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(negedge clk);
      penable = 1'b1;
      #1 begin d = prdata; e = pslverr; end
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_sys_n = 1'b1;
      @(negedge clk);
      #1;
      // Reset state
      chk("R10 pready", {31'b0, pready}, 32'd1);
      chk("R4 wic_en_req reset", {31'b0, wic_en_req}, 32'd1);
      chk("R9 clk_req reset", {31'b0, clk_req}, 32'd1);
      chk("R9 wake_ready reset", {31'b0, wake_ready}, 32'd1);
      apb_rd(12'h000, rd, err); chk("R1 mask0 reset", rd, 32'h0);
      apb_rd(12'h004, rd, err); chk("R2 mask1 reset", rd, 32'h0);
      apb_rd(12'h008, rd, err); chk("R4 sleep reset", rd, 32'h2);

      // Vector table: R5 NMI combine
      foreach (VEC[i]) begin
         apb_wr(12'h000, VEC[i].mask[31:0], err);
         apb_wr(12'h004, {12'h0, VEC[i].mask[51:32]}, err);
         @(negedge clk);
         irq_in = VEC[i].irq;
         #1 chk("R5 nmi vector", {31'b0, nmi_req}, {31'b0, VEC[i].nmi});
      end
      irq_in = '0;

      // R1/R2 readback and upper bits
      apb_wr(12'h000, 32'hA5A5_5A5A, err);
      apb_rd(12'h000, rd, err); chk("R1 mask0 rw", rd, 32'hA5A5_5A5A);
      apb_wr(12'h004, 32'hFFFF_FFFF, err);
      apb_rd(12'h004, rd, err); chk("R2 mask1 width", rd, 32'h000F_FFFF);

      // Mask write while a line is held active: nmi follows on the write edge (R5)
      apb_wr(12'h004, 32'h0, err);
      @(negedge clk);
      irq_in = 52'h0000200000000;   // line 33
      #1 chk("R5 before mask write", {31'b0, nmi_req}, 32'd0);
      apb_wr(12'h004, 32'h2, err);
      #1 chk("R5 after mask write", {31'b0, nmi_req}, 32'd1);
      irq_in = '0;

      // R10 errors
      apb_rd(12'h00C, rd, err);
      chk("R10 err read 0x0C", {31'b0, err}, 32'd1);
      chk("R10 err rdata", rd, 32'h0);
      apb_wr(12'h001, 32'h0, err);
      chk("R10 err unaligned", {31'b0, err}, 32'd1);
      apb_rd(12'h000, rd, err); chk("R10 err write ignored", rd, 32'hA5A5_5A5A);
      chk("R10 no err on good read", {31'b0, err}, 32'd0);

      // R4 ack bit and request
      wic_en_ack = 1'b1;
      apb_wr(12'h008, 32'hFFFF_FFF8, err);
      #1 chk("R4 wic_en_req cleared", {31'b0, wic_en_req}, 32'd0);
      apb_rd(12'h008, rd, err); chk("R4 ack follows input", rd, 32'h4);
      wic_en_ack = 1'b0;
      apb_rd(12'h008, rd, err); chk("R4 ack low", rd, 32'h0);
      apb_wr(12'h008, 32'h2, err);

      // R6 plain sleep drops, R9 wake delay
      @(negedge clk);
      sleeping = 1'b1;
      #1 chk("R6 plain sleep clk_req", {31'b0, clk_req}, 32'd0);
      chk("R9 ready low in sleep", {31'b0, wake_ready}, 32'd0);
      repeat (2) @(negedge clk);
      sleeping = 1'b0;
      #1 chk("R9 ready low on clk return", {31'b0, wake_ready}, 32'd0);
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         #1 chk("R9 wake delay", {31'b0, wake_ready}, (k == 5) ? 32'd1 : 32'd0);
      end

      // R7 light sleep holds, R8 deep overrides
      apb_wr(12'h008, 32'h3, err);
      @(negedge clk);
      sleeping = 1'b1;
      #1 chk("R7 light keeps clk_req", {31'b0, clk_req}, 32'd1);
      chk("R9 ready held", {31'b0, wake_ready}, 32'd1);
      @(negedge clk);
      sleep_deep = 1'b1;
      #1 chk("R8 deep drops clk_req", {31'b0, clk_req}, 32'd0);
      @(negedge clk);
      sleep_deep = 1'b0;
      sleeping = 1'b0;
      repeat (6) @(negedge clk);

      // Collision: clear light-sleep while in ordinary sleep (R6, R9)
      sleeping = 1'b1;
      #1 chk("R7 light sleep before write", {31'b0, clk_req}, 32'd1);
      @(negedge clk);
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h008; pwdata = 32'h2;
      @(negedge clk);
      penable = 1'b1;
      #1 chk("R6 clk_req before write edge", {31'b0, clk_req}, 32'd1);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      #1 chk("R6 clk_req after write edge", {31'b0, clk_req}, 32'd0);
      @(negedge clk);
      sleeping = 1'b0;
      for (int k = 1; k <= 5; k++) begin
         @(negedge clk);
         #1 chk("R9 wake after collision", {31'b0, wake_ready}, (k == 5) ? 32'd1 : 32'd0);
      end

      // R3 warm reset clears masks only
      apb_wr(12'h000, 32'h1234_5678, err);
      apb_wr(12'h004, 32'h000A_BCDE, err);
      apb_wr(12'h008, 32'h1, err);
      @(negedge clk);
      rst_warm_n = 1'b0;
      @(negedge clk);
      rst_warm_n = 1'b1;
      apb_rd(12'h000, rd, err); chk("R3 mask0 cleared", rd, 32'h0);
      apb_rd(12'h004, rd, err); chk("R3 mask1 cleared", rd, 32'h0);
      apb_rd(12'h008, rd, err); chk("R3 sleep kept", rd, 32'h1);

      finish_run();
   end
endmodule